// File: doc/BRIEF.md
# Serial Flash Page Programmer Command Engine

This block sits between a byte-wide host link (for example a UART receiver and transmitter outside the block) and a serial flash organised in 264-byte pages. The host sends fixed four-byte commands: an opcode followed by a 24-bit argument, most significant byte first. The engine turns each command into one or more SPI transactions on its own mode-0 SPI master and returns reply bytes on an output byte stream.

Five host commands exist. Two of them fetch data from the flash: the 4-byte JEDEC identifier and a 264-byte block. One returns the flash status byte. The last two modify the flash: a page write, which carries 264 data bytes and an additive checksum, and a full chip erase. Reads take the argument as a flash byte address. Writes take it as a page number and place it at bit 9 of the flash address. Write and erase each report a single pass (0x01) or fail (0x00) byte, and only after polling the flash shows it ready or a poll budget has run out.

Both byte streams use valid/ready. A byte moves on a rising clock edge where valid and ready are both high. The engine stalls the input by dropping `rx_ready` while it shifts a byte out on SPI, and the host stalls replies by holding `tx_ready` low. Once `tx_valid` is high it stays high with `tx_data` unchanged until the byte is taken. The input is never ready while a reply byte is pending.

Top module: `flash_cmd_engine`

## Requirements
- R1: A command is four accepted input bytes: opcode, then argument bits 23:16, 15:8 and 7:0. `rx_ready` is high after reset, and `rx_ready` and `tx_valid` are never high together.
- R2: Opcode 0x01 runs one SPI transaction with flash opcode 0x9F and returns the next 4 bytes read from the flash, in order.
- R3: Opcode 0x02 runs one SPI transaction with flash opcode 0x03 followed by the 24-bit argument unchanged as the address, and returns the 264 bytes that follow, in order.
- R4: Opcode 0x03 streams the next 264 input bytes into the flash buffer (flash opcode 0x84, address 0), then takes a checksum byte. If the checksum is correct, it issues flash opcode 0x83 with address = page number shifted left by 9, polls until ready and replies 0x01.
- R5: A checksum is correct when the 8-bit sum of the 264 data bytes plus the checksum byte is zero. On a mismatch the reply is 0x00 and no program operation is issued.
- R6: Opcode 0x04 sends the four-byte erase sequence C7 94 80 9A in one transaction, polls, and replies 0x01 only after the flash reports ready.
- R7: Polling reads status with flash opcode 0xD7, where bit 7 set means ready. After POLL_LIMIT polls that read not ready, the reply is 0x00.
- R8: Opcode 0x05 returns the flash status byte (flash opcode 0xD7) as a single reply byte.
- R9: Any other opcode consumes its three argument bytes, produces no reply and no SPI activity, and the next command is decoded normally.
- R10: The SPI bus runs in mode 0. SCK is low whenever chip select is high, MOSI is steady while SCK is high, and chip select stays low for the whole of each flash transaction.
- R11: A reply byte stays valid with unchanged data until `tx_ready` accepts it. Reply streams are complete and in order under any pattern of `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Host command/data byte |
| rx_valid | input | 1 | Host byte present |
| rx_ready | output | 1 | Engine accepts the host byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Host takes the reply byte |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
No reply is due at a fixed cycle. Each reply byte follows one full SPI byte (16 × SPI_DIV clocks) after the previous byte was taken. Write and erase verdicts depend on how many status polls the flash model holds busy. For this reason the bench predicts the reply stream in order and compares every byte in the cycle it is handed over. It also counts the chip-select transactions and program operations that the flash model sees. Fixed-time checks are used only at quiet points: just after reset, and a fixed number of cycles after an unknown command has been consumed, when nothing may have moved.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int LEN_W = 16;

  localparam logic [7:0] H_ID     = 8'h01;
  localparam logic [7:0] H_READ   = 8'h02;
  localparam logic [7:0] H_WRITE  = 8'h03;
  localparam logic [7:0] H_ERASE  = 8'h04;
  localparam logic [7:0] H_STATUS = 8'h05;

  localparam logic [7:0] F_ID     = 8'h9F;
  localparam logic [7:0] F_READ   = 8'h03;
  localparam logic [7:0] F_STATUS = 8'hD7;
  localparam logic [7:0] F_BUFWR  = 8'h84;
  localparam logic [7:0] F_PROG   = 8'h83;

  typedef enum logic [1:0] {BODY_NONE, BODY_TOHOST, BODY_FROMHOST, BODY_POLL} body_e;
  typedef enum logic [1:0] {AFT_IDLE, AFT_CSUM, AFT_POLL_START, AFT_POLL_CHECK} aft_e;
  typedef enum logic [3:0] {
    ST_CMD, ST_HDR, ST_TOHOST, ST_FROMHOST, ST_POLLRD,
    ST_CSEND, ST_NEXT, ST_CSUM, ST_REPLY
  } state_e;

  typedef struct packed {
    logic [3:0][7:0]  hdr;
    logic [2:0]       hlen;
    body_e            body;
    logic [LEN_W-1:0] blen;
    aft_e             aft;
  } txn_t;

  function automatic txn_t mk_txn(input logic [7:0] b0, input logic [7:0] b1,
                                  input logic [7:0] b2, input logic [7:0] b3,
                                  input logic [2:0] n, input body_e bd,
                                  input logic [LEN_W-1:0] len, input aft_e af);
    txn_t t;
    t.hdr  = {b3, b2, b1, b0};
    t.hlen = n;
    t.body = bd;
    t.blen = len;
    t.aft  = af;
    return t;
  endfunction
endpackage

// File: rtl/fce_spi_master.sv
module fce_spi_master #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       done,
  output logic [7:0] dout,
  output logic       sck,
  output logic       mosi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_o, sh_i;
  logic          busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
      sh_o <= '0;
      sh_i <= '0;
      busy <= 1'b0;
      sck  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sh_o <= din;
        cnt  <= '0;
        bitn <= '0;
        sck  <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            sh_i <= {sh_i[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh_o <= {sh_o[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi = sh_o[7];
  assign dout = sh_i;
endmodule

// File: rtl/fce_csum.sv
module fce_csum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum <= '0;
    else if (add)      sum <= sum + din;
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int SPI_DIV    = 2,
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [LEN_W-1:0] PLEN = LEN_W'(PAGE_BYTES);

  state_e           st;
  txn_t             txn, dec_txn;
  logic             dec_go, dec_wr;
  logic [LEN_W-1:0] idx;
  logic [1:0]       bcnt;
  logic [23:0]      arg_q, dec_arg, page_q, prog_addr;
  logic             in_flight, rdy_bit;
  logic [PW-1:0]    poll_cnt;
  logic             spi_start, spi_done;
  logic [7:0]       spi_din, spi_dout, sum;
  logic             rx_fire, sum_clr, sum_add;

  fce_spi_master #(.DIV(SPI_DIV)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(spi_start), .din(spi_din), .miso(spi_miso),
    .done(spi_done), .dout(spi_dout), .sck(spi_sck), .mosi(spi_mosi)
  );

  fce_csum #(.W(8)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add), .din(rx_data), .sum(sum)
  );

  assign rx_ready = (st == ST_CMD) || (st == ST_CSUM) || (st == ST_FROMHOST && !in_flight);
  assign rx_fire  = rx_valid && rx_ready;
  assign sum_add  = rx_fire && (st == ST_FROMHOST);
  assign dec_arg  = {arg_q[15:0], rx_data};
  assign prog_addr = page_q << PAGE_SHIFT;

  // command decode, evaluated on the fourth byte
  always_comb begin
    dec_go  = 1'b1;
    dec_wr  = 1'b0;
    dec_txn = mk_txn(F_STATUS, 8'h00, 8'h00, 8'h00, 3'd1, BODY_TOHOST, LEN_W'(1), AFT_IDLE);
    unique case (arg_q[23:16])
      H_ID:     dec_txn = mk_txn(F_ID, 8'h00, 8'h00, 8'h00, 3'd1, BODY_TOHOST, LEN_W'(4), AFT_IDLE);
      H_READ:   dec_txn = mk_txn(F_READ, dec_arg[23:16], dec_arg[15:8], dec_arg[7:0], 3'd4,
                                 BODY_TOHOST, PLEN, AFT_IDLE);
      H_WRITE: begin
        dec_wr  = 1'b1;
        dec_txn = mk_txn(F_BUFWR, 8'h00, 8'h00, 8'h00, 3'd4, BODY_FROMHOST, PLEN, AFT_CSUM);
      end
      H_ERASE:  dec_txn = mk_txn(8'hC7, 8'h94, 8'h80, 8'h9A, 3'd4, BODY_NONE, '0, AFT_POLL_START);
      H_STATUS: ;
      default:  dec_go = 1'b0;
    endcase
  end

  assign sum_clr = rx_fire && (st == ST_CMD) && (bcnt == 2'd3) && dec_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_CMD;
      txn       <= '0;
      idx       <= '0;
      bcnt      <= '0;
      arg_q     <= '0;
      page_q    <= '0;
      in_flight <= 1'b0;
      rdy_bit   <= 1'b0;
      poll_cnt  <= '0;
      spi_start <= 1'b0;
      spi_din   <= '0;
      spi_cs_n  <= 1'b1;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      spi_start <= 1'b0;
      unique case (st)
        ST_CMD: if (rx_fire) begin
          bcnt  <= bcnt + 2'd1;
          arg_q <= dec_arg;
          if (bcnt == 2'd3 && dec_go) begin
            txn      <= dec_txn;
            page_q   <= dec_arg;
            idx      <= '0;
            spi_cs_n <= 1'b0;
            st       <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (!in_flight) begin
            spi_start <= 1'b1;
            spi_din   <= txn.hdr[idx[1:0]];
            in_flight <= 1'b1;
          end else if (spi_done) begin
            in_flight <= 1'b0;
            if (idx == LEN_W'(txn.hlen - 3'd1)) begin
              idx <= '0;
              unique case (txn.body)
                BODY_NONE:     st <= ST_CSEND;
                BODY_TOHOST:   st <= ST_TOHOST;
                BODY_FROMHOST: st <= ST_FROMHOST;
                BODY_POLL:     st <= ST_POLLRD;
              endcase
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_TOHOST: begin
          if (tx_valid) begin
            if (tx_ready) begin
              tx_valid <= 1'b0;
              if (idx == txn.blen) st <= ST_CSEND;
            end
          end else if (!in_flight) begin
            spi_start <= 1'b1;
            spi_din   <= 8'h00;
            in_flight <= 1'b1;
          end else if (spi_done) begin
            in_flight <= 1'b0;
            tx_data   <= spi_dout;
            tx_valid  <= 1'b1;
            idx       <= idx + 1'b1;
          end
        end
        ST_FROMHOST: begin
          if (rx_fire) begin
            spi_start <= 1'b1;
            spi_din   <= rx_data;
            in_flight <= 1'b1;
          end else if (in_flight && spi_done) begin
            in_flight <= 1'b0;
            if (idx == txn.blen - 1'b1) begin
              idx <= '0;
              st  <= ST_CSEND;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_POLLRD: begin
          if (!in_flight) begin
            spi_start <= 1'b1;
            spi_din   <= 8'h00;
            in_flight <= 1'b1;
          end else if (spi_done) begin
            in_flight <= 1'b0;
            rdy_bit   <= spi_dout[7];
            st        <= ST_CSEND;
          end
        end
        ST_CSEND: begin
          spi_cs_n <= 1'b1;
          st       <= ST_NEXT;
        end
        ST_NEXT: begin
          unique case (txn.aft)
            AFT_IDLE: st <= ST_CMD;
            AFT_CSUM: st <= ST_CSUM;
            AFT_POLL_START: begin
              poll_cnt <= '0;
              txn      <= mk_txn(F_STATUS, 8'h00, 8'h00, 8'h00, 3'd1, BODY_POLL, LEN_W'(1), AFT_POLL_CHECK);
              idx      <= '0;
              spi_cs_n <= 1'b0;
              st       <= ST_HDR;
            end
            AFT_POLL_CHECK: begin
              if (rdy_bit || poll_cnt == PW'(POLL_LIMIT - 1)) begin
                tx_data  <= {7'd0, rdy_bit};
                tx_valid <= 1'b1;
                st       <= ST_REPLY;
              end else begin
                poll_cnt <= poll_cnt + 1'b1;
                idx      <= '0;
                spi_cs_n <= 1'b0;
                st       <= ST_HDR;
              end
            end
          endcase
        end
        ST_CSUM: if (rx_fire) begin
          if (sum + rx_data == 8'h00) begin
            txn      <= mk_txn(F_PROG, prog_addr[23:16], prog_addr[15:8], prog_addr[7:0], 3'd4,
                               BODY_NONE, '0, AFT_POLL_START);
            idx      <= '0;
            spi_cs_n <= 1'b0;
            st       <= ST_HDR;
          end else begin
            tx_data  <= 8'h00;
            tx_valid <= 1'b1;
            st       <= ST_REPLY;
          end
        end
        ST_REPLY: if (tx_ready) begin
          tx_valid <= 1'b0;
          st       <= ST_CMD;
        end
        default: st <= ST_CMD;
      endcase
    end
  end
endmodule

module flash_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  p_half_duplex_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));
  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_mosi_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (.*);

// File: tb/tb_flash_cmd_engine.sv
`timescale 1ns/1ps
module tb_flash_cmd_engine;
  localparam int PB = 264;
  localparam int POLLS = 16;
  localparam int WRITE_BUSY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, tx_ready = 1'b1, spi_miso = 1'b0;
  logic rx_ready, tx_valid, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  flash_cmd_engine #(.PAGE_BYTES(PB), .PAGE_SHIFT(9), .SPI_DIV(2), .POLL_LIMIT(POLLS)) dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  string req = "R1";
  logic [7:0] exp_q[$];
  bit bp_mode = 0;

  // ---------------- flash model ----------------
  logic [7:0] mem [int];
  logic [7:0] pbuf [PB];
  logic [7:0] idv [4] = '{8'h1F, 8'h24, 8'h00, 8'h00};
  logic [7:0] eseq [4];
  logic [7:0] cmd_m, shin, cur, nxt;
  logic [23:0] maddr;
  int nb = 0, bc = 0, busy_left = 0, erase_busy = 4, prog_count = 0, csfall = 0;

  function automatic logic [7:0] rdm(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic handle(input logic [7:0] b);
    if (nb == 0) cmd_m = b;
    if (nb >= 1 && nb <= 3) maddr = {maddr[15:0], b};
    if (nb < 4) eseq[nb] = b;
    nxt = 8'h00;
    case (cmd_m)
      8'h9F: nxt = (nb < 4) ? idv[nb] : 8'h00;
      8'h03: if (nb >= 3) nxt = rdm(int'(maddr) + nb - 3);
      8'hD7: nxt = (busy_left == 0) ? 8'hBC : 8'h3C;
      8'h84: if (nb >= 4 && nb - 4 < PB) pbuf[nb-4] = b;
      default: ;
    endcase
  endtask

  always @(negedge spi_cs_n) begin nb = 0; bc = 0; csfall++; end
  always @(posedge spi_sck) begin
    shin = {shin[6:0], spi_mosi};
    bc++;
    if (bc == 8) begin bc = 0; handle(shin); nb++; end
  end
  always @(negedge spi_sck) begin
    if (bc == 0) begin cur = nxt; spi_miso = cur[7]; end
    else spi_miso = cur[7-bc];
  end
  always @(posedge spi_cs_n) if (nb > 0) begin
    if (cmd_m == 8'h83 && nb == 4) begin
      for (int i = 0; i < PB; i++) mem[int'(maddr) + i] = pbuf[i];
      prog_count++;
      busy_left = WRITE_BUSY;
    end
    if (cmd_m == 8'hC7 && nb == 4 && eseq[1] == 8'h94 && eseq[2] == 8'h80 && eseq[3] == 8'h9A) begin
      mem.delete();
      busy_left = erase_busy;
    end
    if (cmd_m == 8'hD7 && busy_left > 0) busy_left--;
  end

  // ---------------- reply stream compare, every clock ----------------
  always @(negedge clk) begin
    tx_ready = bp_mode ? ((cyc % 5) > 1) : 1'b1;
    if (rst_n && tx_valid && tx_ready) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL %s: unexpected reply byte actual=%02h expected=none", req, tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          mismatched++;
          $display("FAIL %s: reply byte actual=%02h expected=%02h", req, tx_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string r, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a);
    send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  logic [7:0] s;
  int c0, p0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rx_ready after reset", rx_ready, 1);
    check("R1 tx_valid after reset", tx_valid, 0);
    check("R10 cs_n after reset", spi_cs_n, 1);
    check("R10 sck after reset", spi_sck, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: identifier, one transaction
    req = "R2"; c0 = csfall;
    foreach (idv[i]) exp_q.push_back(idv[i]);
    send_cmd(8'h01, 24'h0);
    drain();
    check("R10 one CS for id", csfall - c0, 1);

    // R8: status when ready
    req = "R8";
    exp_q.push_back(8'hBC);
    send_cmd(8'h05, 24'h0);
    drain();

    // R4: write page 5 with correct checksum
    req = "R4"; p0 = prog_count; s = 8'h00;
    send_cmd(8'h03, 24'd5);
    for (int i = 0; i < PB; i++) begin send(pat(i)); s = s + pat(i); end
    exp_q.push_back(8'h01);
    send(8'h00 - s);
    drain();
    check("R4 program issued", prog_count - p0, 1);
    check("R4 flash not busy at pass", busy_left, 0);

    // R3 + R11: read page 5 by byte offset under back-pressure
    req = "R3/R11"; bp_mode = 1; c0 = csfall;
    for (int i = 0; i < PB; i++) exp_q.push_back(pat(i));
    send_cmd(8'h02, 24'h000A00);
    drain();
    check("R10 one CS for read", csfall - c0, 1);

    // R3: unaligned offset runs past page end
    req = "R3"; bp_mode = 0;
    for (int i = 0; i < PB; i++) exp_q.push_back(i + 10 < PB ? pat(i + 10) : 8'hFF);
    send_cmd(8'h02, 24'h000A0A);
    drain();

    // R5: bad checksum on page 6
    req = "R5"; p0 = prog_count; s = 8'h00;
    send_cmd(8'h03, 24'd6);
    for (int i = 0; i < PB; i++) begin send(8'h5A); s = s + 8'h5A; end
    exp_q.push_back(8'h00);
    send(8'h01 - s);
    drain();
    check("R5 no program on mismatch", prog_count - p0, 0);
    for (int i = 0; i < 4; i++) exp_q.push_back(8'hFF);
    for (int i = 4; i < PB; i++) exp_q.push_back(8'hFF);
    send_cmd(8'h02, 24'h000C00);
    drain();

    // R9: unknown opcode
    req = "R9"; c0 = csfall;
    send_cmd(8'h77, 24'h123456);
    repeat (40) @(negedge clk);
    check("R9 no SPI activity", csfall - c0, 0);
    check("R9 no reply", tx_valid, 0);
    req = "R9 realign";
    foreach (idv[i]) exp_q.push_back(idv[i]);
    send_cmd(8'h01, 24'h0);
    drain();

    // R6: erase completes after 4 busy polls
    req = "R6"; erase_busy = 4;
    exp_q.push_back(8'h01);
    send_cmd(8'h04, 24'h0);
    drain();
    check("R6 flash ready at pass", busy_left, 0);
    req = "R6 erased";
    for (int i = 0; i < PB; i++) exp_q.push_back(8'hFF);
    send_cmd(8'h02, 24'h000A00);
    drain();

    // R7: erase longer than the poll budget
    req = "R7"; erase_busy = 50;
    exp_q.push_back(8'h00);
    send_cmd(8'h04, 24'h0);
    drain();
    check("R7 polls consumed", busy_left, 50 - POLLS);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule